// File: doc/BRIEF.md
# Frame Buffer Word Fetch Engine

This block reads a frame of pixel data from memory and fills a word FIFO that the display side drains. It computes each burst's address from a word-aligned base and a running word index. Bursts have a programmed fixed length and go out on a request channel. The returned words are written into the FIFO. When the programmed frame size has been fetched, the index returns to zero, a frame-end pulse is raised, and the next frame starts again at the base.

A new burst is launched only while the FIFO fill level leaves room for two bursts plus a small margin. A burst is never split. After the enable bit is cleared, the engine finishes the burst already in flight and keeps its busy status high until the last word has arrived. Three sticky event flags record FIFO underflow, FIFO overwrite and memory error. Each flag has a mask bit. Enable and disable strobes unmask and mask the sources chosen by a select vector, and an acknowledge vector clears flags.

Back-pressure rules. The request channel is valid/ready. Once `mem_req_valid` is high, it stays high with a stable address and length until `mem_req_ready` is seen. The response channel has no ready: memory may deliver a word in any cycle of an open burst, and the fill threshold is what keeps room for it. The pixel output is valid/ready. `pix_valid` means the FIFO is not empty, and a word leaves on each cycle where both `pix_valid` and `pix_ready` are high.

Top module: `fbdma_fetch`

## Requirements
- R1: The request address is `{cfg_base[31:2],2'b00}` plus 4 times the current word index, so the two low base bits are ignored.
- R2: `mem_req_len` carries the burst word count minus one, equal to `cfg_burst_m1`. The final burst of a frame is shortened to the words remaining, and exactly `mem_req_len+1` response beats are taken per burst.
- R3: When the response beat that completes `cfg_frame_words` words is taken, the word index returns to zero and `frame_end` is high for one cycle.
- R4: A burst is launched only while `dma_en` is high and the FIFO level is below DEPTH − (2·(cfg_burst_m1+1)+3). If that value is zero or less, a burst is launched only when the FIFO is empty.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and its address and length do not change.
- R6: Words come out on `pix_data` in the order they arrived. `pix_valid` is high exactly when the FIFO holds a word.
- R7: `irq_flags[0]` (underflow) is set when `pix_ready` is high while the FIFO is empty.
- R8: `irq_flags[1]` (overwrite) is set when a response word arrives while the FIFO holds DEPTH words. That word is dropped.
- R9: `irq_flags[2]` (memory error) is set by a response beat with `mem_rsp_err` high. That beat counts toward the frame but is not stored.
- R10: All flags and mask bits are zero after reset. `irq_en_wr` unmasks the sources selected by `irq_sel`, `irq_dis_wr` masks them, and `irq_ack` clears the selected flags. `irq` is high when any unmasked flag is set.
- R11: After `dma_en` falls, no new request is raised. `dma_busy` stays high until the final beat of the burst in flight is taken. The next enable starts again at the base address.
- R12: Out of reset, `pix_valid`, `mem_req_valid`, `dma_busy`, `frame_end` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Fetch enable |
| cfg_base | input | 32 | Frame base byte address (low two bits ignored) |
| cfg_frame_words | input | 20 | Frame size in 32-bit words |
| cfg_burst_m1 | input | 10 | Burst length in words minus one |
| dma_busy | output | 1 | Engine has a request or burst open |
| frame_end | output | 1 | One-cycle pulse when a frame completes |
| mem_req_valid | output | 1 | Burst request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Burst start byte address |
| mem_req_len | output | 10 | Burst word count minus one |
| mem_rsp_valid | input | 1 | Response word valid |
| mem_rsp_data | input | 32 | Response word |
| mem_rsp_err | input | 1 | Response beat carries an error |
| pix_valid | output | 1 | FIFO word available |
| pix_ready | input | 1 | Display side takes a word |
| pix_data | output | 32 | FIFO head word |
| irq_en_wr | input | 1 | Unmask the selected sources |
| irq_dis_wr | input | 1 | Mask the selected sources |
| irq_sel | input | 3 | Source select (bit 0 underflow, 1 overwrite, 2 memory error) |
| irq_ack | input | 3 | Clear the selected flags |
| irq_flags | output | 3 | Sticky event flags |
| irq | output | 1 | Any unmasked flag set |

## Verification
The overwrite flag is the hardest event to reach. The fill threshold exists to keep a burst from ever meeting a full FIFO, so ordinary settings never produce it. The bench gets there by programming a burst longer than the FIFO depth: the threshold formula then goes negative and the burst may start only from an empty FIFO. With the display stalled, the words past the depth then arrive while the FIFO is full. The threshold itself is checked by stalling the display and counting the beats the engine fetches before it stops, for two burst lengths. A third case sets up a response error on a chosen beat and confirms that word is missing from the scoreboard stream.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2
  } fetch_state_t;

  localparam int IRQ_N    = 3;
  localparam int IRQ_UFL  = 0;
  localparam int IRQ_OVW  = 1;
  localparam int IRQ_MERR = 2;

endpackage

// File: rtl/fbdma_fifo.sv
module fbdma_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic [LVL_W-1:0]  level,
  output logic              ovw_evt,
  output logic              ufl_evt
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic              full, do_wr, do_rd;

  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));
  assign do_wr   = wr && !full;
  assign do_rd   = rd && !empty;
  assign ovw_evt = wr && full;
  assign ufl_evt = rd && empty;
  assign rdata   = mem[rp];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_wr) wp <= nxt(wp);
      if (do_rd) rp <= nxt(rp);
      case ({do_wr, do_rd})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd) |=> (level == LVL_W'(DEPTH)));
  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd && !wr) |=> empty);

endmodule

// File: rtl/fbdma_ctrl.sv
module fbdma_ctrl
  import fbdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 20,
  parameter int BLEN_W = 10,
  parameter int DEPTH  = 512,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_frame_words,
  input  logic [BLEN_W-1:0] cfg_burst_m1,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              dma_busy,
  output logic              frame_end,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BLEN_W-1:0] mem_req_len,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  output logic              push,
  output logic              err_evt
);

  fetch_state_t      state;
  logic [CNT_W-1:0]  widx, widx_inc, remain;
  logic [BLEN_W-1:0] beats_left, len_next;
  logic [ADDR_W-1:0] addr_next;
  logic [31:0]       need, deep, lvl32;
  logic              launch_ok, beat;
  logic              unused_lowbits;

  assign unused_lowbits = ^cfg_base[1:0];

  // Room check: two bursts plus three words of margin
  assign need  = 32'(cfg_burst_m1) * 32'd2 + 32'd5;
  assign deep  = 32'(DEPTH);
  assign lvl32 = 32'(fifo_level);
  assign launch_ok = (need >= deep) ? (fifo_level == '0) : (lvl32 < (deep - need));

  assign remain    = cfg_frame_words - widx;
  assign len_next  = (remain <= CNT_W'(cfg_burst_m1)) ? BLEN_W'(remain - CNT_W'(1)) : cfg_burst_m1;
  assign addr_next = {cfg_base[ADDR_W-1:2], 2'b00} + ADDR_W'({widx, 2'b00});
  assign widx_inc  = widx + CNT_W'(1);

  assign beat          = (state == ST_DATA) && mem_rsp_valid;
  assign push          = beat && !mem_rsp_err;
  assign err_evt       = beat && mem_rsp_err;
  assign mem_req_valid = (state == ST_REQ);
  assign dma_busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      widx         <= '0;
      beats_left   <= '0;
      mem_req_addr <= '0;
      mem_req_len  <= '0;
      frame_end    <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (!dma_en) begin
            widx <= '0;
          end else if ((cfg_frame_words != '0) && launch_ok) begin
            mem_req_addr <= addr_next;
            mem_req_len  <= len_next;
            state        <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            beats_left <= mem_req_len;
            state      <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (mem_rsp_valid) begin
            if (widx_inc >= cfg_frame_words) begin
              widx      <= '0;
              frame_end <= 1'b1;
            end else begin
              widx <= widx_inc;
            end
            if (beats_left == '0) state <= ST_IDLE;
            else                  beats_left <= beats_left - BLEN_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len)));
  assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
  assert_launch_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> ($past(launch_ok) && $past(dma_en)));
  assert_frame_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $past(beat));
  assert_busy_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> dma_busy);

endmodule

// File: rtl/fbdma_irq.sv
module fbdma_irq
  import fbdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] evt,
  input  logic             en_wr,
  input  logic             dis_wr,
  input  logic [IRQ_N-1:0] sel,
  input  logic [IRQ_N-1:0] ack,
  output logic [IRQ_N-1:0] flags,
  output logic             irq
);

  logic [IRQ_N-1:0] mask;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
        mask[i]  <= 1'b0;
      end else begin
        if (evt[i])      flags[i] <= 1'b1;
        else if (ack[i]) flags[i] <= 1'b0;
        if (en_wr && sel[i])       mask[i] <= 1'b1;
        else if (dis_wr && sel[i]) mask[i] <= 1'b0;
      end
    end

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !evt[i]) |=> !flags[i]);
  end

  assign irq = |(flags & mask);

  assert_dis_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_wr && (&sel) && !en_wr) |=> !irq);

endmodule

// File: rtl/fbdma_fetch.sv
module fbdma_fetch
  import fbdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20,
  parameter int BLEN_W = 10,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_frame_words,
  input  logic [BLEN_W-1:0] cfg_burst_m1,
  output logic              dma_busy,
  output logic              frame_end,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BLEN_W-1:0] mem_req_len,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [DATA_W-1:0] pix_data,
  input  logic              irq_en_wr,
  input  logic              irq_dis_wr,
  input  logic [2:0]        irq_sel,
  input  logic [2:0]        irq_ack,
  output logic [2:0]        irq_flags,
  output logic              irq
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] fifo_level;
  logic             fifo_empty, push, err_evt, ovw_evt, ufl_evt;
  logic [IRQ_N-1:0] evt;

  fbdma_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLEN_W(BLEN_W), .DEPTH(DEPTH)
  ) u_ctrl (
    .clk, .rst_n, .dma_en, .cfg_base, .cfg_frame_words, .cfg_burst_m1,
    .fifo_level, .dma_busy, .frame_end, .mem_req_valid, .mem_req_ready,
    .mem_req_addr, .mem_req_len, .mem_rsp_valid, .mem_rsp_err,
    .push, .err_evt
  );

  fbdma_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .wr(push), .wdata(mem_rsp_data), .rd(pix_ready),
    .rdata(pix_data), .empty(fifo_empty), .level(fifo_level),
    .ovw_evt, .ufl_evt
  );

  assign pix_valid = !fifo_empty;

  always_comb begin
    evt           = '0;
    evt[IRQ_UFL]  = ufl_evt;
    evt[IRQ_OVW]  = ovw_evt;
    evt[IRQ_MERR] = err_evt;
  end

  fbdma_irq u_irq (
    .clk, .rst_n, .evt, .en_wr(irq_en_wr), .dis_wr(irq_dis_wr),
    .sel(irq_sel), .ack(irq_ack), .flags(irq_flags), .irq
  );

  assert_pix_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

endmodule

// File: tb/fbdma_fetch_tb.sv
`timescale 1ns/1ps
module fbdma_fetch_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_en = 1'b0;
  logic [31:0] base = '0;
  logic [19:0] frame = 20'd20;
  logic [9:0]  bm1 = 10'd7;
  logic        dma_busy, frame_end, mem_req_valid, pix_valid, irq;
  logic        mem_req_ready, mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_req_addr, mem_rsp_data, pix_data;
  logic [9:0]  mem_req_len;
  logic        pix_ready = 1'b0;
  logic        irq_en_wr = 1'b0, irq_dis_wr = 1'b0;
  logic [2:0]  irq_sel = '0, irq_ack = '0, irq_flags;

  int n_chk = 0, n_bad = 0;
  int exp_widx = 0, wraps = 0, beats_total = 0, pops = 0, fe_cnt = 0;
  int err_at = -1;
  bit sb_on = 1'b0, stall_tog = 1'b0;
  logic [31:0] expq [$];

  always #2 clk = ~clk;

  fbdma_fetch u_dut (
    .clk, .rst_n, .dma_en, .cfg_base(base), .cfg_frame_words(frame),
    .cfg_burst_m1(bm1), .dma_busy, .frame_end, .mem_req_valid, .mem_req_ready,
    .mem_req_addr, .mem_req_len, .mem_rsp_valid, .mem_rsp_data, .mem_rsp_err,
    .pix_valid, .pix_ready, .pix_data, .irq_en_wr, .irq_dis_wr, .irq_sel,
    .irq_ack, .irq_flags, .irq
  );

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Memory model and scoreboard driver: expected words are queued as sent
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        logic [31:0] a, expa;
        int n, expn;
        a    = mem_req_addr;
        n    = int'(mem_req_len) + 1;
        expa = (base & 32'hFFFF_FFFC) + 32'(4 * exp_widx);
        expn = int'(bm1) + 1;
        if (int'(frame) - exp_widx < expn) expn = int'(frame) - exp_widx;
        check(a == expa, "R1 request address", a, expa);
        check(n == expn, "R2 burst length", n, expn);
        stall_tog = !stall_tog;
        if (stall_tog) begin
          repeat (2) begin
            @(negedge clk);
            check(mem_req_valid && mem_req_addr == a && int'(mem_req_len) + 1 == n,
                  "R5 request held", mem_req_addr, a);
          end
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int i = 0; i < n; i++) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = word_of(a + 32'(4 * i));
          mem_rsp_err   = (i == err_at);
          if (sb_on && i != err_at) expq.push_back(mem_rsp_data);
          beats_total++;
          exp_widx++;
          if (exp_widx >= int'(frame)) begin exp_widx = 0; wraps++; end
          @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        err_at        = -1;
      end
    end
  end

  // Monitor: samples between edges, pops the scoreboard on each transfer
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && pix_valid && pix_ready) begin
        pops++;
        if (sb_on) begin
          if (expq.size() == 0) check(1'b0, "R6 unexpected word", pix_data, 0);
          else begin
            logic [31:0] e;
            e = expq.pop_front();
            check(pix_data == e, "R6 word order", pix_data, e);
          end
        end
      end
      if (rst_n && frame_end) fe_cnt++;
    end
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic stop_and_drain();
    dma_en = 1'b0;
    while (dma_busy) cycles(1);
    pix_ready = 1'b1;
    while (pix_valid) cycles(1);
    cycles(2);
    exp_widx = 0;
  endtask

  task automatic irq_write(input bit en, input logic [2:0] s);
    irq_sel = s;
    if (en) irq_en_wr = 1'b1; else irq_dis_wr = 1'b1;
    cycles(1);
    irq_en_wr = 1'b0; irq_dis_wr = 1'b0; irq_sel = '0;
    cycles(1);
  endtask

  task automatic ack_all();
    irq_ack = 3'b111;
    cycles(1);
    irq_ack = '0;
    cycles(1);
  endtask

  initial begin
    int b0, p0;
    cycles(4);
    rst_n = 1'b1;
    cycles(1);
    // R12 reset state
    check(!pix_valid, "R12 pix_valid", pix_valid, 0);
    check(!mem_req_valid && !dma_busy, "R12 req/busy", {mem_req_valid, dma_busy}, 0);
    check(!frame_end && !irq, "R12 frame_end/irq", {frame_end, irq}, 0);
    check(irq_flags == 3'b000, "R10 flags after reset", irq_flags, 0);

    // R7 underflow, R10 masking
    pix_ready = 1'b1;
    cycles(1);
    pix_ready = 1'b0;
    cycles(1);
    check(irq_flags[0], "R7 underflow flag", irq_flags, 1);
    check(!irq, "R10 masked after reset", irq, 0);
    irq_write(1'b1, 3'b001);
    check(irq, "R10 unmask raises irq", irq, 1);
    ack_all();
    check(irq_flags == 3'b000 && !irq, "R10 ack clears", irq_flags, 0);
    irq_write(1'b0, 3'b111);

    // R1 R2 R3 R6: unaligned base, frame of 20 words in bursts of 8
    base = 32'h0000_1003; frame = 20'd20; bm1 = 10'd7; sb_on = 1'b1;
    pix_ready = 1'b1; dma_en = 1'b1;
    while (pops < 70) cycles(1);
    stop_and_drain();
    check(expq.size() == 0, "R6 scoreboard empty", expq.size(), 0);
    check(wraps >= 3, "R3 frames wrapped", wraps, 3);
    check(fe_cnt == wraps, "R3 frame_end pulses", fe_cnt, wraps);

    // R11 disable mid-burst
    dma_en = 1'b1;
    while (!mem_rsp_valid) cycles(1);
    dma_en = 1'b0;
    check(dma_busy, "R11 busy held after disable", dma_busy, 1);
    while (mem_rsp_valid) cycles(1);
    check(!dma_busy, "R11 busy drops after final beat", dma_busy, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        if (mem_req_valid) seen++;
        cycles(1);
      end
      check(seen == 0, "R11 no request while disabled", seen, 0);
    end
    stop_and_drain();
    check(expq.size() == 0, "R6 scoreboard empty after disable", expq.size(), 0);

    // R4 threshold, burst of 8: limit 493, stops at 496
    base = 32'h0002_0000; frame = 20'd4096; bm1 = 10'd7;
    pix_ready = 1'b0; b0 = beats_total; dma_en = 1'b1;
    cycles(1500);
    check(beats_total - b0 == 496, "R4 fill with 8-word bursts", beats_total - b0, 496);
    check(!dma_busy && !mem_req_valid, "R4 engine idle at threshold", dma_busy, 0);
    stop_and_drain();
    check(expq.size() == 0, "R6 scoreboard after fill", expq.size(), 0);

    // R4 threshold, burst of 4: limit 501, stops at 504
    bm1 = 10'd3; pix_ready = 1'b0; b0 = beats_total; dma_en = 1'b1;
    cycles(2500);
    check(beats_total - b0 == 504, "R4 fill with 4-word bursts", beats_total - b0, 504);
    check(!irq_flags[1], "R8 no overwrite under threshold", irq_flags[1], 0);
    stop_and_drain();
    check(expq.size() == 0, "R6 scoreboard after second fill", expq.size(), 0);

    // R9 error beat skipped, R10 unmask then mask all
    ack_all();
    base = 32'h0000_0400; frame = 20'd20; bm1 = 10'd7; err_at = 3;
    pix_ready = 1'b1; dma_en = 1'b1;
    cycles(60);
    check(irq_flags[2], "R9 memory error flag", irq_flags, 4);
    check(!irq, "R10 error masked", irq, 0);
    irq_write(1'b1, 3'b100);
    check(irq, "R10 error unmasked", irq, 1);
    irq_write(1'b0, 3'b111);
    check(!irq, "R10 disable masks all", irq, 0);
    stop_and_drain();
    check(expq.size() == 0, "R9 error word not delivered", expq.size(), 0);

    // R8 overwrite: 600-word burst into an empty 512-word FIFO
    ack_all();
    sb_on = 1'b0; frame = 20'd4096; bm1 = 10'd599;
    pix_ready = 1'b0; b0 = beats_total; p0 = pops; dma_en = 1'b1;
    cycles(700);
    check(beats_total - b0 == 600, "R4 oversize burst only from empty", beats_total - b0, 600);
    check(irq_flags[1], "R8 overwrite flag", irq_flags, 2);
    stop_and_drain();
    check(pops - p0 == 512, "R8 extra words dropped", pops - p0, 512);

    finish_run();
  end

endmodule